// File: doc/BRIEF.md
# Residue-Split Modular Exponentiator

This block raises an operand to a power modulo a composite modulus that is the product of two coprime odd moduli, each half the datapath width. It splits the work across the two residue channels and reassembles the answer at the end. Every arithmetic step, including the conversions into and out of the residue form, is issued to one shared sequential radix-2 Montgomery multiplier. A single two-operand addition merges the channels, and there is no separate modular reducer.

The caller holds the two half-width moduli, the full modulus and a set of precomputed Montgomery constants on the input pins, then pulses `start`. The base and the exponent are captured on that edge. The run has three parts.

- Each channel first brings the base into its own residue with two full-width Montgomery products.
- Each channel then runs a fixed-length exponentiation over all exponent bits, least significant bit first, using half-width Montgomery products.
- Each channel result is weighted with two more products. The two weighted values are summed and folded below the full modulus, and one full-width product gives the result.

When `z` is valid, `done` pulses for one cycle.

Top module: `crt_exp_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy` is 0, `done` is 0 and `z` is 0.
- R2: A `start` sampled while `busy` is 0 captures `x_in` and `e_in`, and `busy` reads 1 on the next cycle.
- R3: Given odd coprime `mod_a` and `mod_b` greater than 1, `mod_full` = `mod_a`·`mod_b`, and the constants described in the port table, `z` equals `x_in`^`e_in` mod `mod_full` for any `x_in` below `mod_full`, with `z` < `mod_full`.
- R4: Operands larger than either half-width modulus are reduced correctly into each channel, so `x_in` = `mod_full`−1 gives the right result.
- R5: An exponent of 0 yields `z` = 1.
- R6: Every result returned by the shared multiplier is below the modulus it was issued with.
- R7: The channel sum is folded by one conditional subtraction of `mod_full`, so that the merged operand is below `mod_full`. This holds also for the largest moduli.
- R8: `done` is high for exactly one cycle, in the same cycle `busy` returns to 0. `z` holds its value after `done` until the next run completes.
- R9: `done` rises exactly LAT = 7·(N+3) + (4·EW+4)·(N/2+3) + 3 clock edges after the edge that samples `start`, whatever the values of `x_in` and `e_in` (884 for the defaults).
- R10: A `start` pulse while `busy` is 1 is ignored. Neither the result nor the completion cycle of the current run changes, even when `x_in` and `e_in` are changed at the same time.
- R11: All EW exponent bits are used, bit 0 first, so exponents with the top bit set, or with every bit set, give the right result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| x_in | input | N | Base, below `mod_full` |
| e_in | input | EW | Exponent |
| mod_a | input | N/2 | First channel modulus (odd) |
| mod_b | input | N/2 | Second channel modulus (odd, coprime to `mod_a`) |
| mod_full | input | N | Product `mod_a`·`mod_b` |
| r2n_a | input | N/2 | 2^(2N) mod `mod_a` |
| r2n_b | input | N/2 | 2^(2N) mod `mod_b` |
| r2h_a | input | N/2 | 2^N mod `mod_a` (square of the half-width radix) |
| r2h_b | input | N/2 | 2^N mod `mod_b` |
| crt_a | input | N/2 | (`mod_b`^-1 mod `mod_a`)·2^(N/2) mod `mod_a` |
| crt_b | input | N/2 | (`mod_a`^-1 mod `mod_b`)·2^(N/2) mod `mod_b` |
| r2n_full | input | N | 2^(2N) mod `mod_full` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse, `z` valid |
| z | output | N | Result |

## Verification
The result is due a fixed LAT edges after the edge that samples `start`, because each channel always performs every multiply-and-square pair. Each full-width product costs N+3 cycles, each half-width product costs N/2+3 cycles, and the merge costs 3. The bench counts rising edges from the start edge and samples `done`, `busy` and `z` on the following falling edges. It requires `done` to appear at exactly that count, to be gone one edge later, and `z` to stay unchanged. The ignored-start case injects its pulse, with different operands, two hundred edges into a run, and still expects the original count and value.

// File: rtl/crt_exp_pkg.sv
package crt_exp_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_FWD_A,
    PH_FWD_B,
    PH_EXP_INIT,
    PH_EXP_MUL,
    PH_EXP_SQR,
    PH_REV_A,
    PH_REV_B,
    PH_ACC,
    PH_FIN
  } crt_phase_t;

endpackage

// File: rtl/crt_mont_mul.sv
// Sequential radix-2 Montgomery product: z = x*y*2^-K mod m, with K = N or N/2.
module crt_mont_mul #(
  parameter int N = 16,
  parameter int H = N / 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic         half,
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic [N-1:0] m,
  output logic         rdy,
  output logic [N-1:0] z
);
  localparam int CW = $clog2(N);
  localparam int SW = N + 2;

  logic          run, fin;
  logic [CW-1:0] cnt;
  logic [N-1:0]  xs;
  logic [SW-1:0] s, a_sum, s_nx;

  always_comb begin
    a_sum = s + (xs[0] ? {2'b00, y} : '0);
    s_nx  = (a_sum + (a_sum[0] ? {2'b00, m} : '0)) >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      fin <= 1'b0;
      rdy <= 1'b0;
      cnt <= '0;
      xs  <= '0;
      s   <= '0;
      z   <= '0;
    end else begin
      rdy <= 1'b0;
      if (fin) begin
        z   <= (s >= {2'b00, m}) ? N'(s - {2'b00, m}) : N'(s);
        rdy <= 1'b1;
        fin <= 1'b0;
      end else if (run) begin
        s  <= s_nx;
        xs <= xs >> 1;
        if (cnt == '0) begin
          run <= 1'b0;
          fin <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (go) begin
        run <= 1'b1;
        s   <= '0;
        xs  <= x;
        cnt <= half ? CW'(H - 1) : CW'(N - 1);
      end
    end
  end
endmodule

// File: rtl/crt_recomb_acc.sv
// Two-cycle merge: sum the channel values, then fold once below m.
module crt_recomb_acc #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [N-1:0] m,
  output logic         rdy,
  output logic [N-1:0] sum_out
);
  logic         stg;
  logic [N:0]   sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg     <= 1'b0;
      sum     <= '0;
      rdy     <= 1'b0;
      sum_out <= '0;
    end else begin
      rdy <= 1'b0;
      if (stg) begin
        sum_out <= (sum >= {1'b0, m}) ? N'(sum - {1'b0, m}) : N'(sum);
        rdy     <= 1'b1;
        stg     <= 1'b0;
      end else if (go) begin
        sum <= {1'b0, a} + {1'b0, b};
        stg <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/crt_exp_seq.sv
module crt_exp_seq
  import crt_exp_pkg::*;
#(
  parameter int N  = 16,
  parameter int EW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [N-1:0]    x_in,
  input  logic [EW-1:0]   e_in,
  input  logic [N/2-1:0]  mod_a,
  input  logic [N/2-1:0]  mod_b,
  input  logic [N-1:0]    mod_full,
  input  logic [N/2-1:0]  r2n_a,
  input  logic [N/2-1:0]  r2n_b,
  input  logic [N/2-1:0]  r2h_a,
  input  logic [N/2-1:0]  r2h_b,
  input  logic [N/2-1:0]  crt_a,
  input  logic [N/2-1:0]  crt_b,
  input  logic [N-1:0]    r2n_full,
  output logic            busy,
  output logic            done,
  output logic [N-1:0]    z
);
  localparam int H  = N / 2;
  localparam int BW = (EW > 1) ? $clog2(EW) : 1;

  crt_phase_t     ph;
  logic           pend, ch;
  logic [BW-1:0]  bi;
  logic [N-1:0]   xq, t, u, s;
  logic [EW-1:0]  eq;
  logic [N-1:0]   zr [2];

  logic           mm_go, mm_half, mm_rdy, acc_go, acc_rdy;
  logic [N-1:0]   mm_x, mm_y, mm_m, mm_z, acc_out;
  logic [H-1:0]   mi, mo, r2n_i, r2h_i, crt_i;

  // per-channel constant selection
  always_comb begin
    mi    = ch ? mod_b : mod_a;
    mo    = ch ? mod_a : mod_b;
    r2n_i = ch ? r2n_b : r2n_a;
    r2h_i = ch ? r2h_b : r2h_a;
    crt_i = ch ? crt_b : crt_a;
  end

  // operand routing to the shared multiplier
  always_comb begin
    mm_go   = 1'b0;
    mm_half = 1'b0;
    mm_x    = '0;
    mm_y    = '0;
    mm_m    = {{(N-H){1'b0}}, mi};
    case (ph)
      PH_FWD_A:    begin mm_go = !pend; mm_x = xq; mm_y = N'(1); end
      PH_FWD_B:    begin mm_go = !pend; mm_x = t;  mm_y = {{(N-H){1'b0}}, r2n_i}; end
      PH_EXP_INIT: begin mm_go = !pend; mm_half = 1'b1; mm_x = t; mm_y = {{(N-H){1'b0}}, r2h_i}; end
      PH_EXP_MUL:  begin mm_go = !pend; mm_half = 1'b1; mm_x = u; mm_y = s; end
      PH_EXP_SQR:  begin mm_go = !pend; mm_half = 1'b1; mm_x = s; mm_y = s; end
      PH_REV_A:    begin mm_go = !pend; mm_half = 1'b1; mm_x = u; mm_y = {{(N-H){1'b0}}, crt_i}; end
      PH_REV_B:    begin mm_go = !pend; mm_x = t; mm_y = {{(N-H){1'b0}}, mo}; mm_m = mod_full; end
      PH_FIN:      begin mm_go = !pend; mm_x = t; mm_y = r2n_full; mm_m = mod_full; end
      default:     ;
    endcase
    acc_go = (ph == PH_ACC) && !pend;
  end

  crt_mont_mul #(.N(N), .H(H)) mul_i (
    .clk(clk), .rst(rst), .go(mm_go), .half(mm_half),
    .x(mm_x), .y(mm_y), .m(mm_m), .rdy(mm_rdy), .z(mm_z)
  );

  crt_recomb_acc #(.N(N)) acc_i (
    .clk(clk), .rst(rst), .go(acc_go), .a(zr[0]), .b(zr[1]),
    .m(mod_full), .rdy(acc_rdy), .sum_out(acc_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      pend  <= 1'b0;
      ch    <= 1'b0;
      bi    <= '0;
      xq    <= '0;
      eq    <= '0;
      t     <= '0;
      u     <= '0;
      s     <= '0;
      zr[0] <= '0;
      zr[1] <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      z     <= '0;
    end else begin
      done <= 1'b0;
      if (mm_go || acc_go) pend <= 1'b1;
      case (ph)
        PH_IDLE: if (start) begin
          ph   <= PH_FWD_A;
          ch   <= 1'b0;
          xq   <= x_in;
          eq   <= e_in;
          busy <= 1'b1;
        end
        PH_ACC: if (acc_rdy) begin
          pend <= 1'b0;
          t    <= acc_out;
          ph   <= PH_FIN;
        end
        default: if (mm_rdy) begin
          pend <= 1'b0;
          case (ph)
            PH_FWD_A: begin t <= mm_z; ph <= PH_FWD_B; end
            PH_FWD_B: begin t <= mm_z; ph <= PH_EXP_INIT; end
            PH_EXP_INIT: begin
              s  <= mm_z;
              u  <= N'(1);
              bi <= '0;
              ph <= PH_EXP_MUL;
            end
            PH_EXP_MUL: begin
              if (eq[bi]) u <= mm_z;
              ph <= PH_EXP_SQR;
            end
            PH_EXP_SQR: begin
              s <= mm_z;
              if (bi == BW'(EW - 1)) ph <= PH_REV_A;
              else begin
                bi <= bi + 1'b1;
                ph <= PH_EXP_MUL;
              end
            end
            PH_REV_A: begin t <= mm_z; ph <= PH_REV_B; end
            PH_REV_B: begin
              zr[ch] <= mm_z;
              if (ch) ph <= PH_ACC;
              else begin
                ch <= 1'b1;
                ph <= PH_FWD_A;
              end
            end
            PH_FIN: begin
              z    <= mm_z;
              done <= 1'b1;
              busy <= 1'b0;
              ph   <= PH_IDLE;
            end
            default: ph <= PH_IDLE;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/crt_exp_chk.sv
module crt_exp_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] z,
  input logic [N-1:0] mod_full,
  input logic         mm_rdy,
  input logic [N-1:0] mm_z,
  input logic [N-1:0] mm_m,
  input logic         acc_rdy,
  input logic [N-1:0] acc_out
);
  p_busy_on_start_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_result_range_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (z < mod_full));

  p_mul_range_r6: assert property (@(posedge clk) disable iff (rst)
    mm_rdy |-> (mm_z < mm_m));

  p_fold_range_r7: assert property (@(posedge clk) disable iff (rst)
    acc_rdy |-> (acc_out < mod_full));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_z_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(done)) |-> $stable(z));
endmodule

bind crt_exp_seq crt_exp_chk #(.N(N)) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .z(z),
  .mod_full(mod_full), .mm_rdy(mm_rdy), .mm_z(mm_z), .mm_m(mm_m),
  .acc_rdy(acc_rdy), .acc_out(acc_out)
);

// File: tb/crt_exp_seq_tb_top.sv
module crt_exp_seq_tb_top;
  localparam int N   = 16;
  localparam int H   = N / 2;
  localparam int EW  = 16;
  localparam int LAT = 7 * (N + 3) + (4 * EW + 4) * (H + 3) + 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [N-1:0]  x_in = '0;
  logic [EW-1:0] e_in = '0;
  logic [H-1:0]  mod_a = 8'd3, mod_b = 8'd5;
  logic [N-1:0]  mod_full = 16'd15;
  logic [H-1:0]  r2n_a = '0, r2n_b = '0, r2h_a = '0, r2h_b = '0, crt_a = '0, crt_b = '0;
  logic [N-1:0]  r2n_full = '0;
  logic          busy, done;
  logic [N-1:0]  z;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  crt_exp_seq #(.N(N), .EW(EW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .x_in(x_in), .e_in(e_in),
    .mod_a(mod_a), .mod_b(mod_b), .mod_full(mod_full),
    .r2n_a(r2n_a), .r2n_b(r2n_b), .r2h_a(r2h_a), .r2h_b(r2h_b),
    .crt_a(crt_a), .crt_b(crt_b), .r2n_full(r2n_full),
    .busy(busy), .done(done), .z(z)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint unsigned modpow(longint unsigned b, longint unsigned ex, longint unsigned m);
    longint unsigned r  = 1 % m;
    longint unsigned bb = b % m;
    for (int i = 0; i < EW; i++) begin
      if (ex[i]) r = (r * bb) % m;
      bb = (bb * bb) % m;
    end
    return r;
  endfunction

  function automatic longint unsigned gcd(longint unsigned a, longint unsigned b);
    while (b != 0) begin
      longint unsigned tmp = a % b;
      a = b;
      b = tmp;
    end
    return a;
  endfunction

  function automatic longint unsigned inv_mod(longint unsigned a, longint unsigned m);
    for (longint unsigned k = 1; k < m; k++)
      if (((a % m) * k) % m == 1) return k;
    return 0;
  endfunction

  task automatic load_moduli(input longint unsigned a, input longint unsigned b);
    longint unsigned mf = a * b;
    longint unsigned rn = 64'd1 << N;
    longint unsigned rh = 64'd1 << H;
    mod_a    = H'(a);
    mod_b    = H'(b);
    mod_full = N'(mf);
    r2n_a    = H'((rn % a) * (rn % a) % a);
    r2n_b    = H'((rn % b) * (rn % b) % b);
    r2h_a    = H'((rh * rh) % a);
    r2h_b    = H'((rh * rh) % b);
    crt_a    = H'((inv_mod(b, a) * rh) % a);
    crt_b    = H'((inv_mod(a, b) * rh) % b);
    r2n_full = N'((rn % mf) * (rn % mf) % mf);
  endtask

  // One run: pulse start, count edges to done, check value, latency, pulse and hold.
  task automatic run_case(input longint unsigned xv, input longint unsigned ev,
                          input string req, input bit poke);
    longint unsigned expz = modpow(xv, ev, longint'(mod_full));
    int  lat = 0;
    bit  got = 1'b0;
    logic [N-1:0] zs;
    x_in  = N'(xv);
    e_in  = EW'(ev);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", busy, 1);
    while (!got && lat < 3000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (poke && lat == 200) begin
        start = 1'b1;
        x_in  = ~x_in;
        e_in  = ~e_in;
      end
      if (poke && lat == 201) start = 1'b0;
      if (done) got = 1'b1;
    end
    check(req, z, expz);
    check("R9 latency", lat, LAT);
    zs = z;
    @(posedge clk);
    @(negedge clk);
    check("R8 done one cycle", done, 0);
    check("R8 busy cleared", busy, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 z held", z, zs);
  endtask

  initial begin
    longint unsigned a, b, mf;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    check("R1 z in reset", z, 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 z after reset", z, 0);

    // directed corners
    load_moduli(11, 13);
    run_case(100, 37, "R3 basic", 1'b0);
    run_case(142, 0, "R5 zero exponent", 1'b0);
    run_case(142, 1, "R3 unit exponent", 1'b0);
    run_case(0, 5, "R3 zero base", 1'b0);
    run_case(142, 16'hFFFF, "R11 all exponent bits", 1'b0);
    run_case(2, 16'h8000, "R11 top exponent bit", 1'b0);
    run_case(77, 12345, "R10 start while busy", 1'b1);

    load_moduli(255, 253);
    run_case(255 * 253 - 1, 16'hBEEF, "R4 base above both moduli", 1'b0);
    run_case(64999, 16'h7FFF, "R7 fold with largest moduli", 1'b0);
    load_moduli(3, 5);
    run_case(14, 16'h0F0F, "R6 smallest moduli", 1'b0);

    // constrained random
    for (int k = 0; k < 28; k++) begin
      do begin
        a = longint'($urandom_range(255, 3)) | 1;
        b = longint'($urandom_range(255, 3)) | 1;
      end while (a == b || gcd(a, b) != 1);
      load_moduli(a, b);
      mf = a * b;
      run_case(longint'($urandom) % mf, longint'($urandom) & 16'hFFFF, "R3 random", 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule